// File: doc/BRIEF.md
# Quad-I/O Serial Flash Word Reader

This block fetches 32-bit words from a serial NOR flash over a four-line SPI link. After reset it runs a short start-up sequence that puts the flash into continuous-read mode. From then on, each word read begins straight with the address. No instruction byte is sent, which saves eight flash clocks on every access. A system master places a word address on the request port and pulses a trigger. The block answers with the assembled word, a one-cycle done pulse and a busy flag. If a request comes in before start-up has finished, the block holds it and reports busy until the word can be fetched.

The flash clock runs at half the system clock. Each flash clock spends one system cycle low and one high. Outputs change in the low half, and the returned nibble is sampled at the end of the high half. The data lines appear as separate output, output-enable and input vectors, so the pad ring can build the tri-state buffers.

A one-bit mode register can hand the flash pins to a raw single-line SPI path. Through it a processor can issue any command itself, for example to reprogram the device. While that path is selected, the read engine is cut off from the pins and ignores triggers.

Top module: `qspi_flash_reader`

## Requirements
- R1: After reset the block drives chip select low and holds all four IO lines high for 8 flash clocks, which pulls the flash out of continuous-read mode. It then raises chip select for one flash clock. Next comes a start-up read: opcode 0xEB on IO0 for 8 clocks (MSB first, with IO2 and IO3 driven high), byte address 0 as 6 nibbles, mode byte 0xA0 as 2 nibbles, 4 dummy clocks and 8 data clocks whose data is thrown away.
- R2: During reset init_done, busy and rd_done are low and chip select is high. init_done goes high 70 to 80 system cycles after reset is released and never falls again. busy stays low during start-up unless a request is waiting.
- R3: A normal read sends no opcode. It sends the byte address (word address times 4) as 6 nibbles, most significant first, then mode byte 0xA0 as two nibbles, then 4 dummy clocks, then 8 data clocks. One flash clock lasts 2 system cycles: low first, then high.
- R4: The 8 received nibbles form 4 bytes, high nibble first within each byte. The byte at the lowest address lands in rd_data[7:0], and the byte at address+3 lands in rd_data[31:24]. rd_data holds its value until the next read completes.
- R5: Suppose a trigger is seen in a cycle where the block is idle and initialized. Then busy is high from the next cycle on. rd_done is high for exactly one cycle, 41 cycles after the trigger cycle. busy stays high through that cycle and drops after it. A trigger seen while busy is ignored.
- R6: A trigger seen before init_done is high is held, together with its address. busy goes high in the next cycle and stays high. The read starts in the first cycle in which init_done is high.
- R7: Every word address from 0 to 0x3FFFFF can be read. Words at erased locations come back as 0xFFFFFFFF.
- R8: Only the opcode 0xEB and the all-ones exit pattern ever reach the flash. No write, program or erase command is issued.
- R9: The block drives no IO line during the dummy and data clocks. When idle and initialized, chip select is high, the flash clock is low and all output enables are low.
- R10: Writing 1 to the mode bit hands the flash pins to the bypass path. Chip select and clock follow the bypass inputs. IO0 carries the bypass serial-out bit, IO2 and IO3 are driven high, IO1 is an input that appears on byp_miso, and the output enables read 4'b1101. While bypass is selected, triggers produce neither busy nor rd_done. Writing 0 gives the pins back to the read engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_trig | input | 1 | One-cycle read request |
| rd_word_addr | input | 22 | Word address of the read |
| rd_data | output | 32 | Assembled word, lowest byte in bits 7:0 |
| rd_done | output | 1 | One-cycle pulse when rd_data is valid |
| rd_busy | output | 1 | Request waiting or read in progress |
| init_done | output | 1 | Start-up sequence complete |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_bypass | input | 1 | Mode value: 1 selects the raw bypass path |
| byp_cs_n | input | 1 | Bypass chip select |
| byp_sclk | input | 1 | Bypass serial clock |
| byp_mosi | input | 1 | Bypass serial data toward the flash |
| byp_miso | output | 1 | Bypass serial data from the flash (IO1) |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Flash serial clock |
| flash_io_out | output | 4 | Values driven on IO3..IO0 |
| flash_io_oe | output | 4 | Output enables for IO3..IO0 |
| flash_io_in | input | 4 | Values read from IO3..IO0 |

## Verification
The assertions check these properties on every cycle:
- rd_done is a single-cycle pulse that always comes with busy.
- init_done never falls once it is set.
- A trigger that arrives before start-up turns into busy on the next cycle.
- The IO enables are off during the dummy and data phases.
- The pins are quiet whenever the block is idle.
- rd_data changes only at the end of a data phase.
- No done pulse appears while the bypass path is selected.

Other behaviours need the bench's flash model and scenarios:
- the order of the start-up sequence, which takes the flash out of continuous mode and back in
- that no opcode precedes a normal read
- the address scaling and byte order across the full address range
- the all-ones result from erased locations
- the exact 41-cycle latency
- the way a held early request is released

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

    localparam int          CMD_BITS   = 8;
    localparam int          MODE_NIBS  = 2;
    localparam int          DATA_W     = 32;
    localparam int          DATA_NIBS  = DATA_W / 4;
    localparam logic [7:0]  OPC_QREAD  = 8'hEB;
    localparam logic [7:0]  MODE_CONT  = 8'hA0;
    localparam logic [3:0]  EXIT_NIB   = 4'hF;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_BOOT,
        PH_EXIT,
        PH_GAP,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_END
    } phase_e;

    typedef struct packed {
        logic       cs_n;
        logic       sclk;
        logic [3:0] io_out;
        logic [3:0] io_oe;
    } pins_t;

    function automatic logic selects_chip(input phase_e p);
        return (p == PH_EXIT) || (p == PH_CMD) || (p == PH_ADDR) ||
               (p == PH_MODE) || (p == PH_DUMMY) || (p == PH_DATA);
    endfunction

    function automatic logic [DATA_W-1:0] le_word(input logic [DATA_W-1:0] arrival);
        logic [DATA_W-1:0] w;
        for (int b = 0; b < DATA_W / 8; b++) begin
            w[8*b +: 8] = arrival[DATA_W - 8*(b+1) +: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
    import qspi_rd_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DUMMY_CLKS = 4,
    parameter int CW         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              bypass_on,
    output phase_e            st,
    output logic [CW-1:0]     cnt,
    output logic              half,
    output logic [ADDR_W+1:0] byte_addr,
    output logic              in_init,
    output logic              busy,
    output logic              done,
    output logic              init_done
);

    localparam int ADDR_NIBS = (ADDR_W + 2) / 4;

    logic              pend;
    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     seg_len;
    phase_e            nxt;

    always_comb begin
        unique case (st)
            PH_BOOT:  seg_len = CW'(1);
            PH_EXIT:  seg_len = CW'(CMD_BITS);
            PH_GAP:   seg_len = CW'(1);
            PH_CMD:   seg_len = CW'(CMD_BITS);
            PH_ADDR:  seg_len = CW'(ADDR_NIBS);
            PH_MODE:  seg_len = CW'(MODE_NIBS);
            PH_DUMMY: seg_len = CW'(DUMMY_CLKS);
            PH_DATA:  seg_len = CW'(DATA_NIBS);
            default:  seg_len = CW'(1);
        endcase
    end

    always_comb begin
        unique case (st)
            PH_BOOT:  nxt = PH_EXIT;
            PH_EXIT:  nxt = PH_GAP;
            PH_GAP:   nxt = PH_CMD;
            PH_CMD:   nxt = PH_ADDR;
            PH_ADDR:  nxt = PH_MODE;
            PH_MODE:  nxt = PH_DUMMY;
            PH_DUMMY: nxt = PH_DATA;
            PH_DATA:  nxt = PH_END;
            default:  nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_BOOT;
            cnt       <= '0;
            half      <= 1'b0;
            pend      <= 1'b0;
            addr_q    <= '0;
            in_init   <= 1'b1;
            init_done <= 1'b0;
        end else begin
            if (trig && !init_done && !bypass_on && !pend) begin
                pend   <= 1'b1;
                addr_q <= addr_in;
            end
            unique case (st)
                PH_IDLE: begin
                    if (!bypass_on && (trig || pend)) begin
                        if (!pend) addr_q <= addr_in;
                        pend <= 1'b0;
                        st   <= PH_ADDR;
                        cnt  <= '0;
                        half <= 1'b0;
                    end
                end
                PH_END: begin
                    st        <= PH_IDLE;
                    in_init   <= 1'b0;
                    init_done <= 1'b1;
                end
                default: begin
                    if (!half) begin
                        half <= 1'b1;
                    end else begin
                        half <= 1'b0;
                        if (cnt == seg_len - 1'b1) begin
                            cnt <= '0;
                            st  <= nxt;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign byte_addr = in_init ? '0 : {addr_q, 2'b00};
    assign busy      = pend || (!in_init && st != PH_IDLE);
    assign done      = !in_init && st == PH_END;

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
    assert_early_held_R6: assert property (@(posedge clk) disable iff (rst)
        (trig && !init_done && !bypass_on) |=> busy);

endmodule

// File: rtl/qspi_rd_datapath.sv
module qspi_rd_datapath
    import qspi_rd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            st,
    input  logic [CW-1:0]     cnt,
    input  logic              half,
    input  logic              in_init,
    input  logic [ADDR_W+1:0] byte_addr,
    input  logic [3:0]        io_in,
    output pins_t             eng_pins,
    output logic [DATA_W-1:0] rd_data
);

    localparam int BA_W      = ADDR_W + 2;
    localparam int ADDR_NIBS = BA_W / 4;

    logic [DATA_W-1:0] sr;
    logic [BA_W-1:0]   addr_sh;
    logic [7:0]        opc_sh;
    logic [7:0]        mode_sh;
    logic              last_nib;

    always_comb begin
        addr_sh = byte_addr >> (4 * (ADDR_NIBS - 1 - int'(cnt)));
        opc_sh  = OPC_QREAD << int'(cnt);
        mode_sh = MODE_CONT << (4 * int'(cnt));
    end

    always_comb begin
        eng_pins.cs_n = !selects_chip(st);
        eng_pins.sclk = half && selects_chip(st);
        unique case (st)
            PH_EXIT: begin
                eng_pins.io_out = {4{EXIT_NIB[0]}};
                eng_pins.io_oe  = 4'b1111;
            end
            PH_CMD: begin
                eng_pins.io_out = {2'b11, 1'b0, opc_sh[7]};
                eng_pins.io_oe  = 4'b1101;
            end
            PH_ADDR: begin
                eng_pins.io_out = addr_sh[3:0];
                eng_pins.io_oe  = 4'b1111;
            end
            PH_MODE: begin
                eng_pins.io_out = mode_sh[7:4];
                eng_pins.io_oe  = 4'b1111;
            end
            default: begin
                eng_pins.io_out = 4'b0000;
                eng_pins.io_oe  = 4'b0000;
            end
        endcase
    end

    assign last_nib = (cnt == CW'(DATA_NIBS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            rd_data <= '0;
        end else if (st == PH_DATA && half) begin
            sr <= {sr[DATA_W-5:0], io_in};
            if (last_nib && !in_init) begin
                rd_data <= le_word({sr[DATA_W-5:0], io_in});
            end
        end
    end

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st != PH_DATA) |=> $stable(rd_data));

endmodule

// File: rtl/qspi_rd_pinmux.sv
module qspi_rd_pinmux
    import qspi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic       mode_bypass,
    input  pins_t      eng_pins,
    input  logic       byp_cs_n,
    input  logic       byp_sclk,
    input  logic       byp_mosi,
    input  logic [3:0] io_in,
    output logic       bypass_on,
    output pins_t      pins,
    output logic       byp_miso
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_on <= 1'b0;
        end else if (mode_wr) begin
            bypass_on <= mode_bypass;
        end
    end

    always_comb begin
        if (bypass_on) begin
            pins.cs_n   = byp_cs_n;
            pins.sclk   = byp_sclk;
            pins.io_out = {2'b11, 1'b0, byp_mosi};
            pins.io_oe  = 4'b1101;
        end else begin
            pins = eng_pins;
        end
    end

    assign byp_miso = bypass_on && io_in[1];

endmodule

// File: rtl/qspi_flash_reader.sv
module qspi_flash_reader
    import qspi_rd_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DUMMY_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_trig,
    input  logic [ADDR_W-1:0] rd_word_addr,
    output logic [31:0]       rd_data,
    output logic              rd_done,
    output logic              rd_busy,
    output logic              init_done,
    input  logic              mode_wr,
    input  logic              mode_bypass,
    input  logic              byp_cs_n,
    input  logic              byp_sclk,
    input  logic              byp_mosi,
    output logic              byp_miso,
    output logic              flash_cs_n,
    output logic              flash_sclk,
    output logic [3:0]        flash_io_out,
    output logic [3:0]        flash_io_oe,
    input  logic [3:0]        flash_io_in
);

    localparam int MAX_SEG = (DUMMY_CLKS > CMD_BITS) ? DUMMY_CLKS : CMD_BITS;
    localparam int CW      = $clog2(MAX_SEG + 1);

    phase_e            st;
    logic [CW-1:0]     cnt;
    logic              half;
    logic              in_init;
    logic              bypass_on;
    logic [ADDR_W+1:0] byte_addr;
    pins_t             eng_pins;
    pins_t             pins;

    qspi_rd_seq #(
        .ADDR_W     (ADDR_W),
        .DUMMY_CLKS (DUMMY_CLKS),
        .CW         (CW)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .trig      (rd_trig),
        .addr_in   (rd_word_addr),
        .bypass_on (bypass_on),
        .st        (st),
        .cnt       (cnt),
        .half      (half),
        .byte_addr (byte_addr),
        .in_init   (in_init),
        .busy      (rd_busy),
        .done      (rd_done),
        .init_done (init_done)
    );

    qspi_rd_datapath #(
        .ADDR_W (ADDR_W),
        .CW     (CW)
    ) dp_i (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .cnt       (cnt),
        .half      (half),
        .in_init   (in_init),
        .byte_addr (byte_addr),
        .io_in     (flash_io_in),
        .eng_pins  (eng_pins),
        .rd_data   (rd_data)
    );

    qspi_rd_pinmux mux_i (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (mode_wr),
        .mode_bypass (mode_bypass),
        .eng_pins    (eng_pins),
        .byp_cs_n    (byp_cs_n),
        .byp_sclk    (byp_sclk),
        .byp_mosi    (byp_mosi),
        .io_in       (flash_io_in),
        .bypass_on   (bypass_on),
        .pins        (pins),
        .byp_miso    (byp_miso)
    );

    assign flash_cs_n   = pins.cs_n;
    assign flash_sclk   = pins.sclk;
    assign flash_io_out = pins.io_out;
    assign flash_io_oe  = pins.io_oe;

    assert_read_tristate_R9: assert property (@(posedge clk) disable iff (rst)
        (!bypass_on && (st == PH_DUMMY || st == PH_DATA)) |-> flash_io_oe == 4'b0000);
    assert_idle_pins_R9: assert property (@(posedge clk) disable iff (rst)
        (init_done && !rd_busy && !bypass_on) |-> (flash_cs_n && !flash_sclk && flash_io_oe == 4'b0000));
    assert_bypass_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (bypass_on && !rd_busy) |=> !rd_done);

endmodule

// File: tb/qspi_flash_reader_tb_top.sv
module qspi_flash_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_trig = 1'b0;
    logic [21:0] rd_word_addr = '0;
    logic [31:0] rd_data;
    logic        rd_done, rd_busy, init_done;
    logic        mode_wr = 1'b0, mode_bypass = 1'b0;
    logic        byp_cs_n = 1'b1, byp_sclk = 1'b0, byp_mosi = 1'b0;
    logic        byp_miso;
    logic        flash_cs_n, flash_sclk;
    logic [3:0]  flash_io_out, flash_io_oe, flash_io_in;

    always #4 clk = ~clk;

    qspi_flash_reader dut_i (
        .clk(clk), .rst(rst), .rd_trig(rd_trig), .rd_word_addr(rd_word_addr),
        .rd_data(rd_data), .rd_done(rd_done), .rd_busy(rd_busy), .init_done(init_done),
        .mode_wr(mode_wr), .mode_bypass(mode_bypass), .byp_cs_n(byp_cs_n),
        .byp_sclk(byp_sclk), .byp_mosi(byp_mosi), .byp_miso(byp_miso),
        .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk), .flash_io_out(flash_io_out),
        .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in)
    );

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // flash content: top sixteenth of the array is erased
    function automatic logic [7:0] fbyte(input logic [23:0] a);
        if (a[23:20] == 4'hF) return 8'hFF;
        return (a[7:0] * 8'd3) ^ a[15:8] ^ (a[23:16] + 8'd1);
    endfunction

    function automatic logic [31:0] exp_word(input logic [21:0] w);
        logic [23:0] b;
        b = {w, 2'b00};
        return {fbyte(b + 24'd3), fbyte(b + 24'd2), fbyte(b + 24'd1), fbyte(b)};
    endfunction

    // behavioural flash model
    bit          byp_test = 0;
    logic        miso_ovr = 1'b0;
    logic [3:0]  drv = 4'h0;
    bit          cont_m = 1;
    bit          quad = 0;
    int          nclk = 0;
    int          off = 0;
    logic [7:0]  opc = '0;
    logic [23:0] maddr = '0;
    logic [7:0]  mmode = '0;
    logic [23:0] last_addr = '0;
    logic [7:0]  last_mode = '0;
    int          last_off = -1;
    logic [23:0] init_addr = 24'h5A5A5A;
    logic [7:0]  init_mode = '0;
    int          eb_cnt = 0, exit_cnt = 0, illegal = 0;

    assign flash_io_in = byp_test ? {2'b00, miso_ovr, 1'b0} : drv;

    always @(negedge flash_cs_n) begin
        if (!byp_test) begin
            nclk = 0; quad = cont_m; off = cont_m ? 0 : 8;
            opc = '0; maddr = '0; mmode = '0;
        end
    end

    always @(posedge flash_sclk) begin
        if (!flash_cs_n && !byp_test) begin
            if (!quad) begin
                opc = {opc[6:0], flash_io_out[0]};
                if (nclk == 7) begin
                    if (opc == 8'hEB) begin quad = 1; eb_cnt++; end
                    else if (opc != 8'hFF) illegal++;
                end
            end else begin
                int r;
                r = nclk - off;
                if (r < 6) maddr = {maddr[19:0], flash_io_out};
                else if (r < 8) begin
                    mmode = {mmode[3:0], flash_io_out};
                    if (r == 7) begin
                        cont_m = (mmode[5:4] == 2'b10);
                        if (mmode == 8'hFF) exit_cnt++;
                        last_addr = maddr; last_mode = mmode; last_off = off;
                        if (off == 8) begin init_addr = maddr; init_mode = mmode; end
                    end
                end else if (r < 20) begin
                    chk(flash_io_oe == 4'b0000, "R9", 32'(flash_io_oe), 0);
                end
            end
            nclk++;
        end
    end

    always @(negedge flash_sclk) begin
        if (!flash_cs_n && !byp_test && quad) begin
            int r;
            logic [7:0] b;
            r = nclk - off;
            if (r >= 12 && r < 20) begin
                b = fbyte(maddr + 24'((r - 12) / 2));
                drv = ((r - 12) % 2 == 0) ? b[7:4] : b[3:0];
            end
        end
    end

    // cycle reference model, compared on every clock
    bit          active = 0, pend_m = 0, byp_m = 0, init_seen = 0;
    int          age = 0, since_rst = 0, done_cnt = 0;
    logic [21:0] addr_m = '0;

    always @(negedge clk) begin
        if (rst) begin
            active = 0; pend_m = 0; age = 0; since_rst = 0;
        end else if (!finished) begin
            bit exp_done, exp_busy;
            string tg;
            since_rst++;
            if (active) age++;
            exp_done = active && (age == 41);
            exp_busy = active || pend_m;
            tg = pend_m ? "R6" : (byp_m ? "R10" : "R5");
            chk(rd_done === exp_done, tg, 32'(rd_done), 32'(exp_done));
            chk(rd_busy === exp_busy, tg, 32'(rd_busy), 32'(exp_busy));
            if (init_seen) chk(init_done === 1'b1, "R2", 32'(init_done), 1);
            if (init_done && !init_seen) begin
                init_seen = 1;
                chk(since_rst >= 70 && since_rst <= 80, "R2", 32'(since_rst), 77);
            end
            if (exp_done) begin
                chk(rd_data === exp_word(addr_m), addr_m[21:18] == 4'hF ? "R7" : "R4",
                    rd_data, exp_word(addr_m));
                chk(last_addr == {addr_m, 2'b00}, "R3", 32'(last_addr), 32'({addr_m, 2'b00}));
                chk(last_mode == 8'hA0 && last_off == 0, "R3", 32'(last_mode), 32'h0A0);
                active = 0;
                done_cnt++;
            end
            if (!active && !pend_m && init_done && !byp_m)
                chk(flash_cs_n && !flash_sclk && flash_io_oe == 4'b0000, "R9",
                    {flash_cs_n, flash_sclk, flash_io_oe}, 32'h20);
            if (!active && !byp_m && init_done && (rd_trig || pend_m)) begin
                active = 1; age = 0;
                if (!pend_m) addr_m = rd_word_addr;
                pend_m = 0;
            end else if (rd_trig && !init_done && !byp_m && !pend_m) begin
                pend_m = 1; addr_m = rd_word_addr;
            end
        end
    end

    task automatic do_read(input logic [21:0] a);
        int d;
        @(posedge clk);
        while (rd_busy || !init_done) @(posedge clk);
        #2; rd_word_addr = a; rd_trig = 1'b1;
        @(posedge clk); #2; rd_trig = 1'b0;
        d = done_cnt;
        while (done_cnt == d) @(posedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 30000 && !finished) begin
            chk(0, "watchdog", 32'(cyc), 30000);
            summary();
        end
    end

    initial begin
        int d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!rd_busy && !rd_done && !init_done, "R2", {rd_busy, rd_done, init_done}, 0);
        chk(flash_cs_n === 1'b1, "R2", 32'(flash_cs_n), 1);
        @(posedge clk); #2; rst = 1'b0;
        repeat (3) @(posedge clk);
        // early request, held until start-up ends (R6)
        #2; rd_word_addr = 22'h000123; rd_trig = 1'b1;
        @(posedge clk); #2; rd_trig = 1'b0;
        d = done_cnt;
        while (done_cnt == d) @(posedge clk);
        // start-up sequence as seen by the flash (R1)
        chk(exit_cnt == 1, "R1", 32'(exit_cnt), 1);
        chk(eb_cnt == 1, "R1", 32'(eb_cnt), 1);
        chk(init_addr == 24'h0, "R1", 32'(init_addr), 0);
        chk(init_mode == 8'hA0, "R1", 32'(init_mode), 32'hA0);
        // normal reads over the range (R3, R4, R7)
        do_read(22'h000000);
        do_read(22'h2AAAAA);
        do_read(22'h155555);
        do_read(22'h3BFFFF);
        do_read(22'h3FFFFF);
        do_read(22'h3C0000);
        // bypass path (R10)
        @(posedge clk); #2; mode_wr = 1'b1; mode_bypass = 1'b1; byp_test = 1; byp_m = 1;
        @(posedge clk); #2; mode_wr = 1'b0;
        byp_cs_n = 1'b0; byp_sclk = 1'b1; byp_mosi = 1'b1; miso_ovr = 1'b1;
        @(negedge clk);
        chk(!flash_cs_n && flash_sclk && flash_io_out[0] && flash_io_out[3:2] == 2'b11,
            "R10", {flash_cs_n, flash_sclk, flash_io_out}, 32'h1D);
        chk(flash_io_oe == 4'b1101 && byp_miso, "R10", {flash_io_oe, byp_miso}, 32'h1B);
        @(posedge clk); #2;
        byp_cs_n = 1'b1; byp_sclk = 1'b0; byp_mosi = 1'b0; miso_ovr = 1'b0;
        @(negedge clk);
        chk(flash_cs_n && !flash_sclk && !flash_io_out[0] && !byp_miso, "R10",
            {flash_cs_n, flash_sclk, flash_io_out[0], byp_miso}, 32'h8);
        d = done_cnt;
        @(posedge clk); #2; rd_word_addr = 22'h000010; rd_trig = 1'b1;
        @(posedge clk); #2; rd_trig = 1'b0;
        repeat (60) @(posedge clk);
        chk(done_cnt == d, "R10", 32'(done_cnt), 32'(d));
        #2; mode_wr = 1'b1; mode_bypass = 1'b0;
        @(posedge clk); #2; mode_wr = 1'b0;
        @(posedge clk); #2; byp_m = 0; byp_test = 0;
        do_read(22'h000777);
        // trigger while busy is ignored (R5)
        @(posedge clk);
        while (rd_busy) @(posedge clk);
        #2; rd_word_addr = 22'h001000; rd_trig = 1'b1;
        @(posedge clk); #2; rd_trig = 1'b0;
        repeat (10) @(posedge clk);
        #2; rd_word_addr = 22'h002000; rd_trig = 1'b1;
        @(posedge clk); #2; rd_trig = 1'b0;
        repeat (60) @(posedge clk);
        chk(illegal == 0, "R8", 32'(illegal), 0);
        chk(cont_m == 1, "R1", 32'(cont_m), 1);
        summary();
    end

endmodule